// File: doc/BRIEF.md
# Wordline pulsewidth calibration controller

This block runs once at power-up or during system test. For each of its targets it finds the shortest wordline pulse at which the target still reads correctly. A target is a memory instance or one subarray of an instance. The block works with a memory self-test engine through a start/done/pass handshake. It begins each target at the worst-case delay code chosen at design time. While the self-test passes, it lowers the code one step at a time. When a test fails, it keeps the last code that passed.

The targets are processed strictly in index order. Each target has its own code register and a 2-bit status. A target that fails at its starting code gets one optional retest after an external repair step. After the last target has been handled, a done flag rises, and the codes then stay fixed for normal operation.

Top module: `wlpw_cal_ctrl`

## Requirements
- R1: After synchronous reset, every code output equals INIT_CODE, every status is 00, `cal_done` is 0 and `test_start` is 0.
- R2: A `cal_start` pulse while idle clears all statuses, reloads every code with INIT_CODE and tests targets in increasing index order. The first test of each target runs at INIT_CODE.
- R3: After a passing test at a code above MIN_CODE, the target's code drops by exactly one and the target is tested again.
- R4: When a test fails after at least one pass, the target's code becomes the failing code plus one and its status becomes 01 (calibrated).
- R5: When a test passes at MIN_CODE, the code stays at MIN_CODE and the status becomes 11 (stopped at minimum).
- R6: When the first test of a target fails, its code stays at INIT_CODE and its status becomes 10 (failed at initial code). No lower code is tried.
- R7: After a failure at the initial code, a `repair_done` pulse within REPAIR_WAIT cycles triggers exactly one retest at INIT_CODE. If the retest passes, the search continues as in R3 to R5. If the retest fails, the status stays 10. If no pulse arrives in the window, the block moves to the next target.
- R8: While a self-test is running (from `test_start` until `test_done`), the code of the target under test does not change.
- R9: `cal_done` rises only after the last target has been handled. It stays high, and all codes and statuses stay unchanged, until the next `cal_start`.
- R10: Status encoding per target, 2 bits, target t at bits [2t+1:2t]: 00 not calibrated, 01 calibrated, 10 failed at initial code, 11 stopped at minimum code. Code of target t is at bits [CODE_W*t +: CODE_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Starts a calibration pass when idle |
| test_start | output | 1 | One-cycle request to the self-test engine |
| test_done | input | 1 | Self-test finished, result valid |
| test_pass | input | 1 | Self-test result, 1 = all reads correct |
| test_sel | output | IDX_W | Index of the target under test |
| repair_done | input | 1 | Pulse: repair of the failed target is complete |
| code_out | output | N_TGT*CODE_W | Per-target wordline delay codes |
| status_out | output | 2*N_TGT | Per-target calibration status |
| cal_done | output | 1 | Calibration pass complete |

## Verification
A wrong search state shows up at the ports within one test run. A missed decrement, or a double one, shows as a wrong code at the next `test_start`. A wrong store on failure shows as a final code or status that does not match the threshold seen by the bench, as soon as `cal_done` rises. The bench sweeps pass thresholds below, inside and above the code range for every target. It compares the number of tests per target, every trial code and the final code and status against values it computes arithmetically. A code that changes mid-test is caught in the same cycle by the bench's stability probe.

// File: rtl/wlpw_pkg.sv
package wlpw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LAUNCH,
        S_WAIT,
        S_REPAIR,
        S_NEXT
    } seq_state_t;

    localparam logic [1:0] ST_NONE = 2'b00;
    localparam logic [1:0] ST_OK   = 2'b01;
    localparam logic [1:0] ST_FAIL = 2'b10;
    localparam logic [1:0] ST_MIN  = 2'b11;
endpackage

// File: rtl/wlpw_code_bank.sv
module wlpw_code_bank
    import wlpw_pkg::*;
#(
    parameter int N_TGT     = 4,
    parameter int CODE_W    = 4,
    parameter int INIT_CODE = 12,
    parameter int MIN_CODE  = 3,
    parameter int IDX_W     = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_all,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [CODE_W-1:0]         wr_code,
    input  logic [1:0]                wr_stat,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [CODE_W-1:0]         rd_code,
    output logic [N_TGT*CODE_W-1:0]   code_flat,
    output logic [2*N_TGT-1:0]        stat_flat
);
    localparam logic [CODE_W-1:0] INIT_C = CODE_W'(INIT_CODE);
    localparam logic [CODE_W-1:0] MIN_C  = CODE_W'(MIN_CODE);

    logic [CODE_W-1:0] code_q [N_TGT];

    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
        logic [CODE_W-1:0] code_d;
        logic [1:0]        stat_d, stat_q;

        always_comb begin
            code_d = code_q[t];
            stat_d = stat_q;
            if (load_all) begin
                code_d = INIT_C;
                stat_d = ST_NONE;
            end else if (wr_en && (wr_idx == IDX_W'(t))) begin
                code_d = wr_code;
                stat_d = wr_stat;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                code_q[t] <= INIT_C;
                stat_q    <= ST_NONE;
            end else begin
                code_q[t] <= code_d;
                stat_q    <= stat_d;
            end
        end

        assign code_flat[t*CODE_W +: CODE_W] = code_q[t];
        assign stat_flat[2*t +: 2]           = stat_q;
    end

    assign rd_code = code_q[rd_idx];

    // R4: a calibrated result always sits strictly above the minimum code
    assert_ok_above_min_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_stat == ST_OK) |-> (wr_code > MIN_C));
endmodule

// File: rtl/wlpw_seq.sv
module wlpw_seq
    import wlpw_pkg::*;
#(
    parameter int N_TGT       = 4,
    parameter int CODE_W      = 4,
    parameter int INIT_CODE   = 12,
    parameter int MIN_CODE    = 3,
    parameter int REPAIR_WAIT = 16,
    parameter int IDX_W       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_start,
    input  logic              test_done,
    input  logic              test_pass,
    input  logic              repair_done,
    input  logic [CODE_W-1:0] cur_code,
    output logic              test_start,
    output logic [IDX_W-1:0]  tgt_idx,
    output logic              load_all,
    output logic              wr_en,
    output logic [CODE_W-1:0] wr_code,
    output logic [1:0]        wr_stat,
    output logic              cal_done
);
    localparam int WCNT_W = $clog2(REPAIR_WAIT + 1);
    localparam logic [CODE_W-1:0] INIT_C = CODE_W'(INIT_CODE);
    localparam logic [CODE_W-1:0] MIN_C  = CODE_W'(MIN_CODE);
    localparam logic [IDX_W-1:0]  LAST   = IDX_W'(N_TGT - 1);
    localparam logic [WCNT_W-1:0] WLIM   = WCNT_W'(REPAIR_WAIT - 1);

    typedef struct packed {
        seq_state_t        state;
        logic [IDX_W-1:0]  tgt;
        logic              first;
        logic              retried;
        logic [WCNT_W-1:0] wcnt;
        logic              done;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        load_all = 1'b0;
        wr_en    = 1'b0;
        wr_code  = cur_code;
        wr_stat  = ST_NONE;
        case (r_q.state)
            S_IDLE: if (cal_start) begin
                load_all    = 1'b1;
                r_d.tgt     = '0;
                r_d.first   = 1'b1;
                r_d.retried = 1'b0;
                r_d.done    = 1'b0;
                r_d.state   = S_LAUNCH;
            end
            S_LAUNCH: r_d.state = S_WAIT;
            S_WAIT: if (test_done) begin
                wr_en = 1'b1;
                if (test_pass) begin
                    r_d.first = 1'b0;
                    if (cur_code <= MIN_C) begin
                        wr_code   = MIN_C;
                        wr_stat   = ST_MIN;
                        r_d.state = S_NEXT;
                    end else begin
                        wr_code   = cur_code - 1'b1;
                        r_d.state = S_LAUNCH;
                    end
                end else if (r_q.first) begin
                    wr_stat   = ST_FAIL;
                    r_d.wcnt  = '0;
                    r_d.state = r_q.retried ? S_NEXT : S_REPAIR;
                end else begin
                    wr_code   = cur_code + 1'b1;
                    wr_stat   = ST_OK;
                    r_d.state = S_NEXT;
                end
            end
            S_REPAIR: begin
                if (repair_done) begin
                    r_d.retried = 1'b1;
                    wr_en       = 1'b1;
                    wr_stat     = ST_NONE;
                    r_d.state   = S_LAUNCH;
                end else if (r_q.wcnt == WLIM) begin
                    r_d.state = S_NEXT;
                end else begin
                    r_d.wcnt = r_q.wcnt + 1'b1;
                end
            end
            S_NEXT: begin
                if (r_q.tgt == LAST) begin
                    r_d.done  = 1'b1;
                    r_d.state = S_IDLE;
                end else begin
                    r_d.tgt     = r_q.tgt + 1'b1;
                    r_d.first   = 1'b1;
                    r_d.retried = 1'b0;
                    r_d.state   = S_LAUNCH;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state   <= S_IDLE;
            r_q.tgt     <= '0;
            r_q.first   <= 1'b1;
            r_q.retried <= 1'b0;
            r_q.wcnt    <= '0;
            r_q.done    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign test_start = (r_q.state == S_LAUNCH);
    assign tgt_idx    = r_q.tgt;
    assign cal_done   = r_q.done;

    // R8: code under test is held while the engine is busy
    assert_code_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == S_WAIT && !test_done) |=> $stable(cur_code));
    // R3: every stored code lies inside the legal range
    assert_code_range_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_code >= MIN_C && wr_code <= INIT_C));
    // R2: a test request lasts exactly one cycle
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        test_start |=> !test_start);
    // R9: completion only follows the last target
    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_done) |-> ($past(r_q.tgt) == LAST));
endmodule

// File: rtl/wlpw_cal_ctrl.sv
module wlpw_cal_ctrl
    import wlpw_pkg::*;
#(
    parameter int N_TGT       = 4,
    parameter int CODE_W      = 4,
    parameter int INIT_CODE   = 12,
    parameter int MIN_CODE    = 3,
    parameter int REPAIR_WAIT = 16,
    localparam int IDX_W      = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cal_start,
    output logic                    test_start,
    input  logic                    test_done,
    input  logic                    test_pass,
    output logic [IDX_W-1:0]        test_sel,
    input  logic                    repair_done,
    output logic [N_TGT*CODE_W-1:0] code_out,
    output logic [2*N_TGT-1:0]      status_out,
    output logic                    cal_done
);
    logic              load_all, wr_en;
    logic [CODE_W-1:0] wr_code, cur_code;
    logic [1:0]        wr_stat;

    wlpw_seq #(
        .N_TGT(N_TGT), .CODE_W(CODE_W), .INIT_CODE(INIT_CODE),
        .MIN_CODE(MIN_CODE), .REPAIR_WAIT(REPAIR_WAIT), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst(rst), .cal_start(cal_start),
        .test_done(test_done), .test_pass(test_pass),
        .repair_done(repair_done), .cur_code(cur_code),
        .test_start(test_start), .tgt_idx(test_sel),
        .load_all(load_all), .wr_en(wr_en), .wr_code(wr_code),
        .wr_stat(wr_stat), .cal_done(cal_done)
    );

    wlpw_code_bank #(
        .N_TGT(N_TGT), .CODE_W(CODE_W), .INIT_CODE(INIT_CODE),
        .MIN_CODE(MIN_CODE), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst(rst), .load_all(load_all), .wr_en(wr_en),
        .wr_idx(test_sel), .wr_code(wr_code), .wr_stat(wr_stat),
        .rd_idx(test_sel), .rd_code(cur_code),
        .code_flat(code_out), .stat_flat(status_out)
    );
endmodule

// File: tb/sim_wlpw_cal_ctrl.sv
`timescale 1ns/1ps
module sim_wlpw_cal_ctrl;
    localparam int N = 4, CW = 4, INIT = 12, MINC = 3, LAT = 3;

    logic clk = 0, rst = 1, cal_start = 0, test_done = 0, test_pass = 0, repair_done = 0;
    logic test_start, cal_done;
    logic [1:0] test_sel;
    logic [N*CW-1:0] code_out;
    logic [2*N-1:0] status_out;

    int errors = 0, checks = 0;
    int thr [N];
    int rep_thr [N];
    bit rep_en [N];
    bit rep_used [N];
    int tests [N];
    int last_code [N];
    bit last_pass [N];
    int prev_tgt;
    int rep_pend, rep_tgt;

    always #2 clk = ~clk;

    wlpw_cal_ctrl u0 (
        .clk(clk), .rst(rst), .cal_start(cal_start), .test_start(test_start),
        .test_done(test_done), .test_pass(test_pass), .test_sel(test_sel),
        .repair_done(repair_done), .code_out(code_out), .status_out(status_out),
        .cal_done(cal_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cnt_of(input int t);
        if (t > INIT) return 1;
        if (t <= MINC) return INIT - MINC + 1;
        return INIT - t + 2;
    endfunction

    // self-test engine model: pass when the applied code meets the threshold
    initial begin
        rep_pend = 0;
        forever begin
            @(negedge clk);
            test_done   = 0;
            repair_done = 0;
            if (rep_pend > 0) begin
                rep_pend--;
                if (rep_pend == 0) begin
                    repair_done = 1;
                    thr[rep_tgt] = rep_thr[rep_tgt];
                end
            end
            if (test_start) begin
                automatic int t = test_sel;
                automatic int c = code_out[t*CW +: CW];
                automatic int exp_c = (tests[t] > 0 && last_pass[t]) ? last_code[t] - 1 : INIT;
                chk(t >= prev_tgt, "R2 order", t, prev_tgt);
                chk(c == exp_c, "R3 trial code", c, exp_c);
                prev_tgt = t;
                tests[t]++;
                for (int k = 0; k < LAT; k++) begin
                    @(negedge clk);
                    chk(code_out[t*CW +: CW] == c, "R8 stable", code_out[t*CW +: CW], c);
                end
                test_done = 1;
                test_pass = (c >= thr[t]);
                last_code[t] = c;
                last_pass[t] = test_pass;
                if (!test_pass && rep_en[t] && !rep_used[t]) begin
                    rep_used[t] = 1;
                    rep_tgt = t;
                    rep_pend = 3;
                end
            end
        end
    end

    task automatic run_cal(input int ecnt [N], input int ecode [N], input int estat [N]);
        int to;
        for (int t = 0; t < N; t++) begin
            tests[t] = 0; rep_used[t] = 0; last_pass[t] = 0;
        end
        prev_tgt = 0;
        @(negedge clk); cal_start = 1;
        @(negedge clk); cal_start = 0;
        chk(cal_done == 0, "R9 done cleared", cal_done, 0);
        to = 0;
        while (!cal_done && to < 2000) begin @(negedge clk); to++; end
        chk(cal_done == 1, "R9 done", cal_done, 1);
        repeat (20) @(negedge clk);
        chk(cal_done == 1, "R9 done held", cal_done, 1);
        for (int t = 0; t < N; t++) begin
            chk(tests[t] == ecnt[t], "R3 test count", tests[t], ecnt[t]);
            chk(code_out[t*CW +: CW] == ecode[t], "R4 R5 R6 code", code_out[t*CW +: CW], ecode[t]);
            chk(status_out[2*t +: 2] == estat[t], "R10 status", status_out[2*t +: 2], estat[t]);
        end
    endtask

    task automatic normal_run();
        int ec [N], ed [N], es [N];
        for (int t = 0; t < N; t++) begin
            ec[t] = cnt_of(thr[t]);
            if (thr[t] > INIT) begin ed[t] = INIT; es[t] = 2; end        // R6
            else if (thr[t] <= MINC) begin ed[t] = MINC; es[t] = 3; end  // R5
            else begin ed[t] = thr[t]; es[t] = 1; end                    // R4
        end
        run_cal(ec, ed, es);
    endtask

    initial begin
        int ec [N], ed [N], es [N];
        for (int t = 0; t < N; t++) begin rep_en[t] = 0; thr[t] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        for (int t = 0; t < N; t++) begin
            chk(code_out[t*CW +: CW] == INIT, "R1 reset code", code_out[t*CW +: CW], INIT);
            chk(status_out[2*t +: 2] == 0, "R1 reset status", status_out[2*t +: 2], 0);
        end
        chk(cal_done == 0 && test_start == 0, "R1 reset flags", cal_done, 0);

        // sweep thresholds below, inside and above the code range
        for (int k = 0; k < 15; k++) begin
            for (int t = 0; t < N; t++) thr[t] = (k + 4 * t) % 15;
            normal_run();
        end

        // R7: repair then passing retest continues search
        for (int t = 0; t < N; t++) thr[t] = 8;
        thr[1] = 14; rep_en[1] = 1; rep_thr[1] = 6;
        thr[2] = 14; rep_en[2] = 1; rep_thr[2] = 14;
        for (int t = 0; t < N; t++) begin ec[t] = cnt_of(8); ed[t] = 8; es[t] = 1; end
        ec[1] = 1 + cnt_of(6); ed[1] = 6;  es[1] = 1;
        ec[2] = 2;             ed[2] = INIT; es[2] = 2;
        run_cal(ec, ed, es);

        // R7: no repair pulse in the window moves on after one test
        for (int t = 0; t < N; t++) rep_en[t] = 0;
        thr[0] = 13; thr[1] = 2; thr[2] = 12; thr[3] = 13;
        normal_run();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule